// File: doc/BRIEF.md
# Invalidating Snoop Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped, write-back cache whose peers snoop one shared bus and use invalidation. Each line carries a tag and one of four states: invalid, clean-exclusive, clean-shared and modified. Processor requests come in one at a time over a request/done handshake. Snooped bus events are applied in the cycle they arrive.

A processor miss takes the line over. If the old line is modified, it is first written back to memory. The block then issues a read, or a read-for-ownership for a write. One cycle after that request it samples a wired-OR sharing input driven by the other caches. A clean read fill becomes exclusive when no peer holds the line and shared when one does. An exclusive line can later be written with no bus traffic. A shared line must first broadcast an invalidate.

Snooped reads demote the local copy to shared and offer the data to the peer. Snooped write-misses and invalidates drop the copy. A modified line hit by a snoop also raises a writeback flag. A combinational lookup port reports the state of the line addressed by the processor address, so the state array can be observed.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line reads as invalid (code 0) on `line_state`, and `cpu_done`, `bus_valid`, `snp_supply` and `snp_wb` are low. State codes are: 0 invalid, 1 clean-exclusive, 2 clean-shared, 3 modified.
- R2: A read miss issues a bus read (`bus_cmd` 0) with the request address. `shared_in` is sampled in the cycle after the one in which `bus_valid` shows the request. The line fills to clean-shared if that sample is 1 and to clean-exclusive if it is 0. `cpu_done` rises in the cycle after the sample.
- R3: A write hit on a clean-exclusive or modified line ends in modified and puts nothing on the bus.
- R4: A write hit on a clean-shared line issues one invalidate (`bus_cmd` 2) for the address, in the same cycle as `cpu_done`, and ends in modified.
- R5: A write miss issues a read-for-ownership (`bus_cmd` 1) and fills to modified, whatever `shared_in` is.
- R6: When a fill completes, `cpu_fill_c2c` is high with `cpu_done` exactly when `shared_in` was sampled as 1, meaning a peer supplies the data.
- R7: A snooped read (`snp_kind` 0) that hits a valid line leaves it clean-shared. In the next cycle `snp_supply` is 1, and `snp_wb` is 1 only if the line was modified.
- R8: A snooped write-miss (`snp_kind` 1) or invalidate (`snp_kind` 2) that hits a valid line makes it invalid. A write-miss also raises `snp_supply`, and raises `snp_wb` when the line was modified. An invalidate raises neither.
- R9: A miss that evicts a modified line first issues a writeback (`bus_cmd` 3) carrying the victim's address, in the cycle before the fill request. A clean victim is dropped without a writeback.
- R10: A snoop of kind 3, or one whose tag misses, changes no line state and raises neither `snp_supply` nor `snp_wb`.
- R11: A read hit completes with `cpu_done` in the cycle after the request is first presented, with no bus transaction and no state change.
- R12: A processor request presented in the same cycle as a snoop to the same line index waits. The snoop's effect is applied first, and the request then proceeds against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | AW | Processor line address; low bits are the index |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_fill_c2c | output | 1 | Fill data supplied by a peer cache |
| line_state | output | 2 | State of the line addressed by `cpu_addr` (0 on tag miss) |
| snp_valid | input | 1 | Snooped bus event present |
| snp_kind | input | 2 | 0 read, 1 write-miss, 2 invalidate, 3 none |
| snp_addr | input | AW | Snooped line address |
| shared_in | input | 1 | Wired-OR sharing indication from peer caches |
| bus_valid | output | 1 | One-cycle bus transaction pulse |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | AW | Address of the bus transaction |
| snp_supply | output | 1 | This cache supplies data for the snooped event |
| snp_wb | output | 1 | Snooped modified line is being written back to memory |

## Verification
The bench drives the sharing input to its inverse in every cycle except the one sampling slot. A controller that samples a cycle early or late therefore fills exclusive instead of shared, or the other way round. Few tags per index force frequent evictions, so a missing or misaddressed writeback of a modified victim, or a spurious one for a clean victim, shows up in the transaction sequence. The directed cases include a silent write on an exclusive line, which a wrong design would follow with an invalidate. They also include a snoop that lands in the same cycle as a processor request to the same index, where a design that does not stall would act on the stale state.

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int AW     = 8,
  parameter int NLINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_done,
  output logic          cpu_fill_c2c,
  output logic [1:0]    line_state,
  input  logic          snp_valid,
  input  logic [1:0]    snp_kind,
  input  logic [AW-1:0] snp_addr,
  input  logic          shared_in,
  output logic          bus_valid,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic          snp_supply,
  output logic          snp_wb
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int TW = AW - IW;

  localparam logic [1:0] ST_I = 2'd0, ST_E = 2'd1, ST_S = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] BC_RD = 2'd0, BC_RFO = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3;
  localparam logic [1:0] SK_RD = 2'd0, SK_WM = 2'd1, SK_INV = 2'd2;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_FILL = 2'd1, PH_WAIT = 2'd2, PH_SAMP = 2'd3;

  logic [1:0]    st_q  [NLINES];
  logic [TW-1:0] tag_q [NLINES];
  logic [1:0]    ph_q;
  logic          pend_we_q;
  logic [AW-1:0] pend_addr_q;

  wire [IW-1:0] cidx = cpu_addr[IW-1:0];
  wire [TW-1:0] ctag = cpu_addr[AW-1:IW];
  wire [IW-1:0] sidx = snp_addr[IW-1:0];
  wire [TW-1:0] stag = snp_addr[AW-1:IW];
  wire [IW-1:0] pidx = pend_addr_q[IW-1:0];

  wire chit    = (st_q[cidx] != ST_I) && (tag_q[cidx] == ctag);
  wire shit    = (st_q[sidx] != ST_I) && (tag_q[sidx] == stag);
  wire snp_act = snp_valid && (snp_kind != 2'd3) && shit;
  wire accept  = (ph_q == PH_IDLE) && cpu_req && !cpu_done &&
                 !(snp_valid && (sidx == cidx));

  assign line_state = chit ? st_q[cidx] : ST_I;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
      ph_q         <= PH_IDLE;
      pend_we_q    <= 1'b0;
      pend_addr_q  <= '0;
      cpu_done     <= 1'b0;
      cpu_fill_c2c <= 1'b0;
      bus_valid    <= 1'b0;
      bus_cmd      <= BC_RD;
      bus_addr     <= '0;
      snp_supply   <= 1'b0;
      snp_wb       <= 1'b0;
    end else begin
      cpu_done     <= 1'b0;
      cpu_fill_c2c <= 1'b0;
      bus_valid    <= 1'b0;
      snp_supply   <= 1'b0;
      snp_wb       <= 1'b0;

      if (snp_act) begin
        case (snp_kind)
          SK_RD: begin
            snp_supply <= 1'b1;
            snp_wb     <= (st_q[sidx] == ST_M);
            st_q[sidx] <= ST_S;
          end
          SK_WM: begin
            snp_supply <= 1'b1;
            snp_wb     <= (st_q[sidx] == ST_M);
            st_q[sidx] <= ST_I;
          end
          SK_INV: st_q[sidx] <= ST_I;
          default: ;
        endcase
      end

      case (ph_q)
        PH_IDLE: if (accept) begin
          if (chit) begin
            cpu_done <= 1'b1;
            if (cpu_we) begin
              if (st_q[cidx] == ST_S) begin
                bus_valid <= 1'b1;
                bus_cmd   <= BC_INV;
                bus_addr  <= cpu_addr;
              end
              st_q[cidx] <= ST_M;
            end
          end else begin
            pend_we_q   <= cpu_we;
            pend_addr_q <= cpu_addr;
            st_q[cidx]  <= ST_I;
            bus_valid   <= 1'b1;
            if (st_q[cidx] == ST_M) begin
              bus_cmd  <= BC_WB;
              bus_addr <= {tag_q[cidx], cidx};
              ph_q     <= PH_FILL;
            end else begin
              bus_cmd  <= cpu_we ? BC_RFO : BC_RD;
              bus_addr <= cpu_addr;
              ph_q     <= PH_WAIT;
            end
          end
        end
        PH_FILL: begin
          bus_valid <= 1'b1;
          bus_cmd   <= pend_we_q ? BC_RFO : BC_RD;
          bus_addr  <= pend_addr_q;
          ph_q      <= PH_WAIT;
        end
        PH_WAIT: ph_q <= PH_SAMP;
        default: begin
          st_q[pidx]   <= pend_we_q ? ST_M : (shared_in ? ST_S : ST_E);
          tag_q[pidx]  <= pend_addr_q[AW-1:IW];
          cpu_done     <= 1'b1;
          cpu_fill_c2c <= shared_in;
          ph_q         <= PH_IDLE;
        end
      endcase
    end
  end

  // R7
  wb_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |-> snp_supply);

  // R4
  inval_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == BC_INV) |-> cpu_done);

  // R2
  fill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_cmd == BC_RD || bus_cmd == BC_RFO)) |=> (!bus_valid && !cpu_done));

  // R9
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == BC_WB) |=> (bus_valid && (bus_cmd == BC_RD || bus_cmd == BC_RFO)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  localparam int AW = 8;
  localparam int NL = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0, bus_addr;
  logic cpu_done, cpu_fill_c2c, bus_valid, snp_supply, snp_wb;
  logic [1:0] line_state, bus_cmd, snp_kind = 2'd3;
  logic snp_valid = 0, shared_in = 0;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  logic [1:0] m_st [NL];
  logic [5:0] m_tag [NL];

  always #5 clk = ~clk;

  snoop_coh_ctrl #(.AW(AW), .NLINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_fill_c2c(cpu_fill_c2c), .line_state(line_state),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr), .shared_in(shared_in),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .snp_supply(snp_supply), .snp_wb(snp_wb));

  task automatic chk(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [1:0] m_look(logic [AW-1:0] a);
    if (m_st[a[1:0]] != 0 && m_tag[a[1:0]] == a[AW-1:2]) return m_st[a[1:0]];
    return 2'd0;
  endfunction

  // returns {supply, wb} and updates the model
  function automatic logic [1:0] m_snoop(logic [1:0] k, logic [AW-1:0] a);
    logic [1:0] s;
    s = m_look(a);
    if (s == 0 || k == 3) return 2'b00;
    if (k == 0) begin m_st[a[1:0]] = 2; return {1'b1, s == 3}; end
    m_st[a[1:0]] = 0;
    if (k == 1) return {1'b1, s == 3};
    return 2'b00;
  endfunction

  task automatic snoop(logic [1:0] k, logic [AW-1:0] a, string req);
    logic [1:0] e;
    e = m_snoop(k, a);
    @(negedge clk);
    snp_valid = 1; snp_kind = k; snp_addr = a;
    @(negedge clk);
    snp_valid = 0; snp_kind = 3;
    chk({req, " snp_supply"}, snp_supply, e[1]);
    chk({req, " snp_wb"}, snp_wb, e[0]);
    cpu_addr = a; #1;
    chk({req, " state after snoop"}, line_state, m_look(a));
  endtask

  // sk==3: no simultaneous snoop
  task automatic access(logic we, logic [AW-1:0] a, logic sh, logic [1:0] sk, string req);
    logic [1:0] es, s, vs, e_sn;
    int ncmd, cyc, fillk;
    logic [1:0] ecmd [2];
    logic [AW-1:0] eadr [2];
    logic [1:0] gcmd [3];
    logic [AW-1:0] gadr [3];
    int gn;
    bit hit;
    e_sn = m_snoop(sk, a);
    s = m_look(a); hit = (s != 0); ncmd = 0;
    if (hit) begin
      if (we && s == 2) begin ecmd[0] = 2; eadr[0] = a; ncmd = 1; end
      es = we ? 2'd3 : s;
    end else begin
      vs = m_st[a[1:0]];
      if (vs == 3) begin ecmd[0] = 3; eadr[0] = {m_tag[a[1:0]], a[1:0]}; ncmd = 1; end
      ecmd[ncmd] = we ? 2'd1 : 2'd0; eadr[ncmd] = a; ncmd++;
      es = we ? 2'd3 : (sh ? 2'd2 : 2'd1);
    end
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; shared_in = !sh;
    if (sk != 3) begin snp_valid = 1; snp_kind = sk; snp_addr = a; end
    gn = 0; cyc = 0; fillk = -1;
    while (cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (snp_valid) begin
        snp_valid = 0; snp_kind = 3;
        chk({req, " concurrent snp_supply"}, snp_supply, e_sn[1]);
        chk({req, " concurrent snp_wb"}, snp_wb, e_sn[0]);
      end
      shared_in = !sh;
      if (fillk >= 0 && cyc == fillk + 1) shared_in = sh;
      if (bus_valid) begin
        if (gn < 3) begin gcmd[gn] = bus_cmd; gadr[gn] = bus_addr; end
        gn++;
        if (bus_cmd == 0 || bus_cmd == 1) fillk = cyc;
      end
      if (cpu_done) break;
    end
    chk({req, " done seen"}, int'(cpu_done), 1);
    chk({req, " bus transaction count"}, gn, ncmd);
    for (int i = 0; i < ncmd && i < gn; i++) begin
      chk({req, " bus_cmd"}, gcmd[i], ecmd[i]);
      chk({req, " bus_addr"}, gadr[i], eadr[i]);
    end
    if (!hit) chk({req, " cpu_fill_c2c"}, cpu_fill_c2c, we ? int'(sh) : int'(sh));
    if (hit && sk == 3) chk({req, " hit latency (R11)"}, cyc, 1);
    chk({req, " final state"}, line_state, es);
    cpu_req = 0; shared_in = 0;
    m_st[a[1:0]] = es; m_tag[a[1:0]] = a[AW-1:2];
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    for (int i = 0; i < NL; i++) begin
      cpu_addr = AW'(i); #1;
      chk("R1 reset state", line_state, 0);
    end
    chk("R1 cpu_done", cpu_done, 0);
    chk("R1 bus_valid", bus_valid, 0);
    chk("R1 snp_supply", snp_supply, 0);
    chk("R1 snp_wb", snp_wb, 0);

    access(0, 8'h04, 0, 3, "R2 read miss unshared");
    access(0, 8'h04, 1, 3, "R11 read hit");
    access(1, 8'h04, 1, 3, "R3 silent write on exclusive");
    access(1, 8'h04, 0, 3, "R3 write on modified");
    snoop(0, 8'h04, "R7 snoop read on modified");
    access(1, 8'h04, 0, 3, "R4 write on shared");
    snoop(2, 8'h04, "R8 snoop invalidate");
    access(0, 8'h05, 1, 3, "R2 R6 read miss shared");
    snoop(0, 8'h05, "R7 snoop read on shared");
    snoop(1, 8'h05, "R8 snoop write-miss");
    access(1, 8'h06, 1, 3, "R5 write miss");
    snoop(3, 8'h06, "R10 snoop kind none");
    snoop(1, 8'h46, "R10 snoop tag miss");
    access(0, 8'h86, 0, 3, "R9 dirty victim");
    access(0, 8'hC6, 1, 3, "R9 clean victim");
    access(0, 8'h07, 1, 3, "R12 setup");
    access(1, 8'h07, 0, 2, "R12 concurrent invalidate");

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {6'($urandom % 4), 2'($urandom % 4)};
      if ($urandom % 10 < 6)
        access(1'($urandom % 2), a, 1'($urandom % 2), 3, "R2-R11 random access");
      else
        snoop(2'($urandom % 4), a, "R7 R8 R10 random snoop");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule